// File: doc/BRIEF.md
# Addressed Serial DAC Control Port

This block receives 10-bit control words from an external controller over a gated serial clock, a serial data line and a latch strobe. The first two bits of each word select one of four targets: two 8-bit DAC shadow latches, or one of two per-channel offset-trim registers. Each trim register holds a source select (factory or user), a direction and a 4-bit magnitude.

The three serial pins are sampled in the faster system clock domain, and their edges are detected there. On a latch falling edge, a complete word is committed to the target it addresses. The same event then copies both shadow latches into the two DAC output registers together.

An active-low power-down input holds the DAC outputs at zero. When it is released, a ready flag rises after a programmable settle count.

The serial pins carry no valid/ready handshake. The external controller paces every word and the port always accepts it, so there is no back-pressure path. All other pins are plain levels.

Top module: `serial_dac_ctl`

## Requirements
- R1: Each rising edge of `sclk` shifts `sdata` into a 10-bit register, MSB first. When more than 10 edges arrive, only the most recent 10 bits are kept.
- R2: A falling edge of `latch` commits the word only if at least 10 bits have been shifted since the previous latch fall or since reset. Otherwise no shadow latch and no trim register changes. Every latch fall restarts the bit count.
- R3: Word bits [9:8] select the target: 00 is trim A, 01 is DAC 1, 10 is DAC 0, 11 is trim B. For a DAC target, bits [7:0] are the straight-binary code.
- R4: For a trim target, bit 5 is the source (1 = user, 0 = factory), bit 4 is the direction (1 = raise, 0 = lower) and bits [3:0] are the magnitude. Bits 7 and 6 have no effect.
- R5: Every latch fall copies both shadow latches into both DAC outputs at the same time. The DAC outputs do not change at any other time while powered.
- R6: The trim outputs change on the 3rd system clock edge after `latch` falls at the pin. The DAC outputs change on the 4th edge.
- R7: When an `sclk` rise and a `latch` fall are seen in the same system cycle, the commit uses the word held before that shift. The bit count then restarts at 1.
- R8: While `pwr_n` is low, both DAC outputs read zero from the next edge onwards and latch events leave them zero. Shadow latches and trim registers can still be written in this state.
- R9: `ready` is low while `pwr_n` is low. It rises on exactly the `SETTLE_CYCLES`-th edge at which `pwr_n` is high and reset is low.
- R10: Synchronous reset clears both DAC outputs and both shadows, and clears `ready` and the bit count. It sets both trims to factory source, lower direction and magnitude 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Gated serial clock, idles low |
| sdata | input | 1 | Serial data, idles low |
| latch | input | 1 | Commit/load strobe, acts on its falling edge |
| pwr_n | input | 1 | Active-low power-down |
| dac0_code | output | 8 | DAC 0 output code |
| dac1_code | output | 8 | DAC 1 output code |
| trim_a_user | output | 1 | Trim A source: 1 user, 0 factory |
| trim_a_raise | output | 1 | Trim A direction: 1 raise, 0 lower |
| trim_a_mag | output | 4 | Trim A magnitude |
| trim_b_user | output | 1 | Trim B source |
| trim_b_raise | output | 1 | Trim B direction |
| trim_b_mag | output | 4 | Trim B magnitude |
| ready | output | 1 | Settle interval elapsed after power-up |

## Verification
A shift edge and a commit can land in the same system cycle. To provoke this, the bench raises `sclk` and drops `latch` at the same instant after a full word has been loaded. Both pins pass through synchronizers of equal depth, so both edges are detected in one cycle.

The check has two parts. First, the committed target must show the pre-shift word. Second, exactly nine more bits and a further latch must be enough to commit a second word whose MSB is the bit shifted during the collision.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  localparam int SEL_W  = 2;
  localparam int TRIM_W = 4;

  localparam int SAMPLE_LEVEL = 0;
  localparam int SAMPLE_RISE  = 1;
  localparam int SAMPLE_FALL  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_TRIM_A = 2'b00,
    SEL_DAC1   = 2'b01,
    SEL_DAC0   = 2'b10,
    SEL_TRIM_B = 2'b11
  } sel_e;

  typedef struct packed {
    logic              user_src;
    logic              raise;
    logic [TRIM_W-1:0] mag;
  } trim_t;

  localparam trim_t TRIM_RESET = '{user_src: 1'b0, raise: 1'b0, mag: '0};
endpackage

// File: rtl/sdc_pin_sampler.sv
`timescale 1ns/1ps
module sdc_pin_sampler #(
  parameter int STAGES = 2,
  parameter int MODE   = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic sig_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  if (MODE == sdc_pkg::SAMPLE_LEVEL) begin : g_level
    assign sig_o = chain[STAGES-1];
  end else begin : g_edge
    logic last;
    always_ff @(posedge clk) begin
      if (rst) last <= 1'b0;
      else     last <= chain[STAGES-1];
    end
    if (MODE == sdc_pkg::SAMPLE_RISE) begin : g_rise
      assign sig_o = chain[STAGES-1] & ~last;
    end else begin : g_fall
      assign sig_o = ~chain[STAGES-1] & last;
    end
  end
endmodule

// File: rtl/sdc_shifter.sv
`timescale 1ns/1ps
module sdc_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      if (shift_i) sr <= {sr[WORD_W-2:0], bit_i};
      if (clear_i)                     cnt <= shift_i ? ONE : '0;
      else if (shift_i && cnt != FULL) cnt <= cnt + ONE;
    end
  end

  assign word_o = sr;
  assign full_o = (cnt == FULL);

  // R2
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst) cnt <= FULL);
  // R7
  collide_count_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && shift_i) |=> (cnt == ONE));
endmodule

// File: rtl/sdc_router.sv
`timescale 1ns/1ps
module sdc_router
  import sdc_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int WORD_W = CODE_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] shadow0_o,
  output logic [CODE_W-1:0] shadow1_o,
  output trim_t             trim_a_o,
  output trim_t             trim_b_o,
  output logic              load_o
);
  sel_e              sel;
  logic [CODE_W-1:0] code;
  trim_t             trim_word;
  logic              accept;

  assign sel       = sel_e'(word_i[WORD_W-1 -: SEL_W]);
  assign code      = word_i[CODE_W-1:0];
  assign trim_word = '{user_src: word_i[TRIM_W+1], raise: word_i[TRIM_W],
                       mag: word_i[TRIM_W-1:0]};
  assign accept    = commit_i && full_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow0_o <= '0;
      shadow1_o <= '0;
      trim_a_o  <= TRIM_RESET;
      trim_b_o  <= TRIM_RESET;
      load_o    <= 1'b0;
    end else begin
      load_o <= commit_i;
      if (accept) begin
        case (sel)
          SEL_TRIM_A: trim_a_o  <= trim_word;
          SEL_DAC1:   shadow1_o <= code;
          SEL_DAC0:   shadow0_o <= code;
          SEL_TRIM_B: trim_b_o  <= trim_word;
          default:    ;
        endcase
      end
    end
  end

  // R2
  short_word_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !full_i) |=> ($stable(shadow0_o) && $stable(shadow1_o) &&
                               $stable(trim_a_o) && $stable(trim_b_o)));
endmodule

// File: rtl/sdc_out_stage.sv
`timescale 1ns/1ps
module sdc_out_stage #(
  parameter int CODE_W        = 8,
  parameter int SETTLE_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_n_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] shadow0_i,
  input  logic [CODE_W-1:0] shadow1_i,
  output logic [CODE_W-1:0] dac0_o,
  output logic [CODE_W-1:0] dac1_o,
  output logic              ready_o
);
  localparam int SC_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SC_W-1:0] LAST = SC_W'(SETTLE_CYCLES - 1);

  logic [SC_W-1:0] settle;

  always_ff @(posedge clk) begin
    if (rst || !pwr_n_i) begin
      dac0_o <= '0;
      dac1_o <= '0;
    end else if (load_i) begin
      dac0_o <= shadow0_i;
      dac1_o <= shadow1_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_n_i) begin
      settle  <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      if (settle == LAST) ready_o <= 1'b1;
      else                settle  <= settle + SC_W'(1);
    end
  end

  // R8
  pd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_n_i |=> (dac0_o == '0 && dac1_o == '0));
  // R9
  pd_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_n_i |=> !ready_o);
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_n_i && !load_i) |=> ($stable(dac0_o) && $stable(dac1_o)));
endmodule

// File: rtl/serial_dac_ctl.sv
`timescale 1ns/1ps
module serial_dac_ctl
  import sdc_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              latch,
  input  logic              pwr_n,
  output logic [CODE_W-1:0] dac0_code,
  output logic [CODE_W-1:0] dac1_code,
  output logic              trim_a_user,
  output logic              trim_a_raise,
  output logic [TRIM_W-1:0] trim_a_mag,
  output logic              trim_b_user,
  output logic              trim_b_raise,
  output logic [TRIM_W-1:0] trim_b_mag,
  output logic              ready
);
  localparam int WORD_W = CODE_W + SEL_W;

  logic              sclk_rise, latch_fall, data_bit, full, load;
  logic [WORD_W-1:0] word;
  logic [CODE_W-1:0] shadow0, shadow1;
  trim_t             trim_a, trim_b;

  sdc_pin_sampler #(.STAGES(SYNC_STAGES), .MODE(SAMPLE_RISE)) u_sclk (
    .clk(clk), .rst(rst), .pin_i(sclk), .sig_o(sclk_rise));
  sdc_pin_sampler #(.STAGES(SYNC_STAGES), .MODE(SAMPLE_LEVEL)) u_sdata (
    .clk(clk), .rst(rst), .pin_i(sdata), .sig_o(data_bit));
  sdc_pin_sampler #(.STAGES(SYNC_STAGES), .MODE(SAMPLE_FALL)) u_latch (
    .clk(clk), .rst(rst), .pin_i(latch), .sig_o(latch_fall));

  sdc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_i(sclk_rise), .bit_i(data_bit),
    .clear_i(latch_fall), .word_o(word), .full_o(full));

  sdc_router #(.CODE_W(CODE_W)) u_route (
    .clk(clk), .rst(rst), .commit_i(latch_fall), .full_i(full), .word_i(word),
    .shadow0_o(shadow0), .shadow1_o(shadow1), .trim_a_o(trim_a),
    .trim_b_o(trim_b), .load_o(load));

  sdc_out_stage #(.CODE_W(CODE_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_out (
    .clk(clk), .rst(rst), .pwr_n_i(pwr_n), .load_i(load),
    .shadow0_i(shadow0), .shadow1_i(shadow1),
    .dac0_o(dac0_code), .dac1_o(dac1_code), .ready_o(ready));

  assign trim_a_user  = trim_a.user_src;
  assign trim_a_raise = trim_a.raise;
  assign trim_a_mag   = trim_a.mag;
  assign trim_b_user  = trim_b.user_src;
  assign trim_b_raise = trim_b.raise;
  assign trim_b_mag   = trim_b.mag;
endmodule

// File: tb/sim_serial_dac_ctl.sv
`timescale 1ns/1ps
module sim_serial_dac_ctl;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rst, sclk, sdata, latch, pwr_n;
  logic [7:0] dac0_code, dac1_code;
  logic trim_a_user, trim_a_raise, trim_b_user, trim_b_raise, ready;
  logic [3:0] trim_a_mag, trim_b_mag;

  always #2.5 clk = ~clk;

  serial_dac_ctl #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .latch(latch), .pwr_n(pwr_n),
    .dac0_code(dac0_code), .dac1_code(dac1_code),
    .trim_a_user(trim_a_user), .trim_a_raise(trim_a_raise), .trim_a_mag(trim_a_mag),
    .trim_b_user(trim_b_user), .trim_b_raise(trim_b_raise), .trim_b_mag(trim_b_mag),
    .ready(ready));

  typedef struct packed {
    logic [7:0] d0;
    logic [7:0] d1;
    logic [5:0] ta;
    logic [5:0] tb;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  event  chk_ev;
  int    nchk = 0, nfail = 0;
  bit    done = 0;

  // independent model state
  logic [9:0] m_hist = '0;
  int         m_cnt = 0;
  logic [7:0] m_sh0 = 0, m_sh1 = 0, m_d0 = 0, m_d1 = 0;
  logic [5:0] m_ta = 0, m_tb = 0;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, "dac0", dac0_code, e.d0);
        check(r, "dac1", dac1_code, e.d1);
        check(r, "trimA", {2'b00, trim_a_user, trim_a_raise, trim_a_mag}, {2'b00, e.ta});
        check(r, "trimB", {2'b00, trim_b_user, trim_b_raise, trim_b_mag}, {2'b00, e.tb});
      end
    end
  end

  task automatic push(input string req);
    exp_q.push_back('{d0: m_d0, d1: m_d1, ta: m_ta, tb: m_tb});
    req_q.push_back(req);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic model_latch();
    if (m_cnt >= 10) begin
      case (m_hist[9:8])
        2'b00: m_ta = m_hist[5:0];
        2'b01: m_sh1 = m_hist[7:0];
        2'b10: m_sh0 = m_hist[7:0];
        default: m_tb = m_hist[5:0];
      endcase
    end
    m_cnt = 0;
    if (pwr_n) begin
      m_d0 = m_sh0;
      m_d1 = m_sh1;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) sdata = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    m_hist = {m_hist[8:0], b};
    if (m_cnt < 10) m_cnt++;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    sdata = 1'b0;
  endtask

  task automatic pulse_latch(input string req);
    @(negedge clk) latch = 1'b1;
    repeat (3) @(negedge clk);
    latch = 1'b0;
    repeat (5) @(negedge clk);
    model_latch();
    push(req);
  endtask

  initial begin
    rst = 1'b1; pwr_n = 1'b1; sclk = 1'b0; sdata = 1'b0; latch = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10", "dac0", dac0_code, 8'h00);
    check("R10", "dac1", dac1_code, 8'h00);
    check("R10", "trimA", {2'b00, trim_a_user, trim_a_raise, trim_a_mag}, 8'h00);
    check("R10", "trimB", {2'b00, trim_b_user, trim_b_raise, trim_b_mag}, 8'h00);
    check("R10", "ready", {7'b0, ready}, 8'h00);
    // R9 settle after reset
    repeat (SETTLE - 1) @(negedge clk);
    check("R9", "ready early", {7'b0, ready}, 8'h00);
    @(negedge clk);
    check("R9", "ready", {7'b0, ready}, 8'h01);

    // R3 DAC routing, R5 both loaded together
    send_bits({6'b0, 2'b10, 8'hA5}, 10); pulse_latch("R3");
    send_bits({6'b0, 2'b01, 8'h3C}, 10); pulse_latch("R5");
    // R4 trim fields, bits 7:6 ignored
    send_bits({6'b0, 2'b00, 2'b11, 1'b1, 1'b0, 4'h9}, 10); pulse_latch("R4");
    send_bits({6'b0, 2'b11, 2'b00, 1'b0, 1'b1, 4'h6}, 10); pulse_latch("R4");

    // R6 latency: DAC output on 4th edge after latch fall
    send_bits({6'b0, 2'b10, 8'h5A}, 10);
    @(negedge clk) latch = 1'b1;
    repeat (3) @(negedge clk);
    latch = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", "dac0 before 4th edge", dac0_code, 8'hA5);
    @(negedge clk);
    check("R6", "dac0 at 4th edge", dac0_code, 8'h5A);
    model_latch();
    push("R6");

    // R5 hold: shifting without a latch leaves outputs alone
    send_bits({6'b0, 2'b01, 8'hFF}, 10);
    check("R5", "dac1 held", dac1_code, 8'h3C);
    pulse_latch("R5");

    // R2 short word: nine bits then latch, nothing commits
    send_bits({6'b0, 2'b10, 8'h00}, 9);
    pulse_latch("R2");

    // R1 overlong burst: last ten bits count
    send_bits({3'b0, 3'b111, 2'b01, 8'h81}, 13);
    pulse_latch("R1");

    // R7 collision of shift edge and latch fall
    send_bits({6'b0, 2'b01, 8'h22}, 10);
    @(negedge clk) latch = 1'b1;
    repeat (4) @(negedge clk);
    sdata = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    latch = 1'b0;
    model_latch();
    m_hist = {m_hist[8:0], 1'b1};
    m_cnt = 1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    sdata = 1'b0;
    push("R7");
    send_bits({7'b0, 9'b0_0110_0110}, 9);
    pulse_latch("R7");

    // R8 power-down
    @(negedge clk) pwr_n = 1'b0;
    m_d0 = 0; m_d1 = 0;
    @(negedge clk);
    check("R8", "dac0 pd", dac0_code, 8'h00);
    check("R9", "ready pd", {7'b0, ready}, 8'h00);
    send_bits({6'b0, 2'b10, 8'h77}, 10); pulse_latch("R8");
    send_bits({6'b0, 2'b00, 2'b00, 1'b1, 1'b1, 4'h3}, 10); pulse_latch("R8");
    pwr_n = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    check("R9", "ready early", {7'b0, ready}, 8'h00);
    @(negedge clk);
    check("R9", "ready", {7'b0, ready}, 8'h01);
    check("R8", "dac0 still zero", dac0_code, 8'h00);
    pulse_latch("R8");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      nfail++;
      $display("FAIL all watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule